// File: doc/BRIEF.md
# Generation-Bit Interrupt Event Queue

This block is a ring of event slots in on-chip storage that carries interrupt numbers from one producer to one consumer. Each slot is one word. The top bit of the word is a generation marker and the remaining bits hold the event number. There is no shared occupancy counter. The producer stamps every slot it fills with its current polarity. The consumer judges a slot as new when the slot's marker differs from the consumer's own toggle. Each side keeps its own index and toggle, and each toggle inverts every time that side's index wraps back to the first slot.

A producer offers an event number on the append port. If the slot it would fill still holds an entry the consumer has not popped, the event is dropped and an overflow flag is raised. Otherwise the event is written, and an optional notify output pulses. The consumer asks for the head entry with a pop request. It gets back either a valid event or an empty indication. One particular event number is reserved as the inter-processor marker, and it is flagged on its own output.

The ring depth, the payload width, the value of the reserved marker and whether notify is built are all parameters. The default ring holds 1024 slots, which is one 4 KiB page of 32-bit words.

Top module: `gen_event_queue`

## Requirements
- R1: A slot is `PAY_W+1` bits wide. The most significant bit (bit 31 by default) is the generation marker, and bits `PAY_W-1:0` (30:0 by default) carry the event number. Any event number, including all ones and zero, comes back unchanged on `pop_event`.
- R2: A pop of a slot whose marker equals the consumer toggle gives `pop_valid`=0 and `pop_event`=0, and leaves the consumer index unchanged. The next event appended is the next one popped.
- R3: Accepted events are popped in the order they were appended. On each valid pop the consumer index advances to (index+1) masked by (DEPTH-1).
- R4: The consumer toggle inverts whenever its index wraps to 0. After a full ring has been drained, a pop at the wrap boundary reports empty, even though every slot still holds the previous lap's data.
- R5: The producer writes the marker as the inverse of its own toggle. Its toggle starts at 0 and inverts on each wrap, so entries keep arriving in order on the second, third and later laps.
- R6: While reset is held and after it is released, `pop_valid`, `pop_event`, `pop_ipi`, `notify` and `push_overflow` are 0. Both indices and both toggles are 0, and every slot is zero.
- R7: An append made when DEPTH entries are still unpopped is dropped, and `push_overflow` is 1 in the cycle after the request. The stored entries are not disturbed.
- R8: When a pop and an append hit the same slot in the same cycle on an empty ring, the write is seen first, so the pop returns the new event.
- R9: With `NOTIFY_EN`=1, `notify` is 1 in the cycle after each accepted append and 0 after a dropped one or when there is no append.
- R10: `pop_ipi` is 1 exactly when a valid pop returns the event number `IPI_CODE` (default 2^24). Neighbouring numbers do not raise it.
- R11: The pop results (`pop_valid`, `pop_event`, `pop_ipi`) appear in the cycle after `pop_req`. Without a request they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | Append request |
| push_event | input | PAY_W | Event number to append |
| push_overflow | output | 1 | Previous append was dropped because the ring was full |
| notify | output | 1 | Previous append was accepted (when built) |
| pop_req | input | 1 | Pop request for the head slot |
| pop_valid | output | 1 | Previous pop returned an entry |
| pop_event | output | PAY_W | Event number returned, zero when empty |
| pop_ipi | output | 1 | Returned event is the inter-processor marker |

## Verification
Every output of this block is a register loaded on the edge that samples the request. Pop results, the notify pulse and the overflow flag therefore all belong to the cycle right after the request. The bench drives its inputs on the falling edge. A behavioural model, built from a queue of integers, updates on the rising edge that the design also uses. Each output is compared with that model on the next falling edge, one cycle after the stimulus and before the next request can change anything. The directed phases align the consumer to the first slot before each of three full laps, so that the empty result at each wrap boundary is checked explicitly.

// File: rtl/evq_pkg.sv
package evq_pkg;

   // True for a power of two of at least two
   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

   // Smallest legal payload that still leaves room for a marker bit
   localparam int unsigned MIN_PAY_W = 2;

endpackage

// File: rtl/evq_producer.sv
module evq_producer #(
   parameter int unsigned IDX_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_valid,
   input  logic [IDX_W-1:0] cons_idx,
   input  logic             cons_tog,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic             wr_gen,
   output logic             overflow
);

   localparam logic [IDX_W-1:0] IDX_MASK = '1;

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_nxt;
   logic             tog_q;
   logic             lapped;

   // Same slot on opposite laps means the consumer still owns it
   assign lapped  = (idx_q == cons_idx) && (tog_q != cons_tog);
   assign wr_en   = push_valid && !lapped;
   assign wr_idx  = idx_q;
   assign wr_gen  = ~tog_q;
   assign idx_nxt = (idx_q + 1'b1) & IDX_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q    <= '0;
         tog_q    <= 1'b0;
         overflow <= 1'b0;
      end else begin
         overflow <= push_valid && lapped;
         if (wr_en) begin
            idx_q <= idx_nxt;
            if (idx_nxt == '0) begin
               tog_q <= ~tog_q;
            end
         end
      end
   end

endmodule

// File: rtl/evq_ram.sv
module evq_ram #(
   parameter int unsigned DEPTH = 1024,
   parameter int unsigned WIDTH = 32,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic             collide;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) begin
            mem[i] <= '0;
         end
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   // Write-first: a same-cycle write to the read slot is forwarded
   assign collide = wr_en && (wr_addr == rd_addr);
   assign rd_data = collide ? wr_data : mem[rd_addr];

endmodule

// File: rtl/evq_consumer.sv
module evq_consumer #(
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned PAY_W    = 31,
   parameter int unsigned IPI_CODE = 32'h0100_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pop_req,
   input  logic [PAY_W:0]   rd_entry,
   output logic [IDX_W-1:0] rd_idx,
   output logic             cons_tog,
   output logic             pop_valid,
   output logic [PAY_W-1:0] pop_event,
   output logic             pop_ipi
);

   localparam logic [IDX_W-1:0] IDX_MASK = '1;
   localparam logic [PAY_W-1:0] IPI_VAL  = PAY_W'(IPI_CODE);

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_nxt;
   logic             tog_q;
   logic             live;
   logic             take;
   logic [PAY_W-1:0] payload;

   assign payload  = rd_entry[PAY_W-1:0];
   assign live     = rd_entry[PAY_W] != tog_q;
   assign take     = pop_req && live;
   assign idx_nxt  = (idx_q + 1'b1) & IDX_MASK;
   assign rd_idx   = idx_q;
   assign cons_tog = tog_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q     <= '0;
         tog_q     <= 1'b0;
         pop_valid <= 1'b0;
         pop_event <= '0;
         pop_ipi   <= 1'b0;
      end else begin
         pop_valid <= take;
         pop_event <= take ? payload : '0;
         pop_ipi   <= take && (payload == IPI_VAL);
         if (take) begin
            idx_q <= idx_nxt;
            if (idx_nxt == '0) begin
               tog_q <= ~tog_q;
            end
         end
      end
   end

endmodule

// File: rtl/gen_event_queue.sv
module gen_event_queue #(
   parameter int unsigned DEPTH     = 1024,
   parameter int unsigned PAY_W     = 31,
   parameter int unsigned IPI_CODE  = 32'h0100_0000,
   parameter bit          NOTIFY_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_valid,
   input  logic [PAY_W-1:0] push_event,
   output logic             push_overflow,
   output logic             notify,
   input  logic             pop_req,
   output logic             pop_valid,
   output logic [PAY_W-1:0] pop_event,
   output logic             pop_ipi
);

   localparam int unsigned IDX_W   = $clog2(DEPTH);
   localparam int unsigned ENTRY_W = PAY_W + 1;

   if (!evq_pkg::is_pow2(DEPTH)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (PAY_W < evq_pkg::MIN_PAY_W || PAY_W > 31) begin : g_bad_pay
      $error("PAY_W out of range");
   end
   if (PAY_W < 32 && IPI_CODE >= (64'd1 << PAY_W)) begin : g_bad_ipi
      $error("IPI_CODE does not fit in the payload");
   end

   logic               wr_en;
   logic [IDX_W-1:0]   wr_idx;
   logic               wr_gen;
   logic [IDX_W-1:0]   cons_idx;
   logic               cons_tog;
   logic [ENTRY_W-1:0] rd_entry;

   evq_producer #(.IDX_W(IDX_W)) u_prod (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (push_valid),
      .cons_idx   (cons_idx),
      .cons_tog   (cons_tog),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_gen     (wr_gen),
      .overflow   (push_overflow)
   );

   evq_ram #(.DEPTH(DEPTH), .WIDTH(ENTRY_W), .AW(IDX_W)) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_idx),
      .wr_data ({wr_gen, push_event}),
      .rd_addr (cons_idx),
      .rd_data (rd_entry)
   );

   evq_consumer #(.IDX_W(IDX_W), .PAY_W(PAY_W), .IPI_CODE(IPI_CODE)) u_cons (
      .clk       (clk),
      .rst_n     (rst_n),
      .pop_req   (pop_req),
      .rd_entry  (rd_entry),
      .rd_idx    (cons_idx),
      .cons_tog  (cons_tog),
      .pop_valid (pop_valid),
      .pop_event (pop_event),
      .pop_ipi   (pop_ipi)
   );

   if (NOTIFY_EN) begin : g_notify
      logic notify_q;
      always_ff @(posedge clk) begin
         if (!rst_n) notify_q <= 1'b0;
         else        notify_q <= wr_en;
      end
      assign notify = notify_q;
   end else begin : g_no_notify
      assign notify = 1'b0;
   end

endmodule

// File: rtl/gen_event_queue_chk.sv
module gen_event_queue_chk #(
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned PAY_W    = 31,
   parameter int unsigned IPI_CODE = 32'h0100_0000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             push_valid,
   input logic             push_overflow,
   input logic             notify,
   input logic             pop_req,
   input logic             pop_valid,
   input logic [PAY_W-1:0] pop_event,
   input logic             pop_ipi,
   input logic [IDX_W-1:0] cons_idx,
   input logic             cons_tog
);

   AST_EMPTY_HOLDS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pop_req) && !pop_valid) |-> $stable(cons_idx)); // R2

   AST_POP_STEPS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |-> (cons_idx == IDX_W'($past(cons_idx) + 1'b1))); // R3

   AST_WRAP_FLIPS_TOG: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_valid && cons_idx == '0) |-> (cons_tog != $past(cons_tog))); // R4

   AST_DROP_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      push_overflow |-> $past(push_valid)); // R7

   AST_NO_NOTIFY_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !(notify && push_overflow)); // R9

   AST_IPI_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      pop_ipi |-> (pop_valid && pop_event == PAY_W'(IPI_CODE))); // R10

   AST_RESULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pop_req) |-> !pop_valid); // R11

endmodule

bind gen_event_queue gen_event_queue_chk #(
   .IDX_W(IDX_W), .PAY_W(PAY_W), .IPI_CODE(IPI_CODE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .push_valid    (push_valid),
   .push_overflow (push_overflow),
   .notify        (notify),
   .pop_req       (pop_req),
   .pop_valid     (pop_valid),
   .pop_event     (pop_event),
   .pop_ipi       (pop_ipi),
   .cons_idx      (cons_idx),
   .cons_tog      (cons_tog)
);

// File: tb/tb_gen_event_queue.sv
module tb_gen_event_queue;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;
   localparam int PAY_W      = 31;
   localparam int IPI        = 1 << 24;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             push_valid = 1'b0;
   logic [PAY_W-1:0] push_event = '0;
   logic             pop_req = 1'b0;
   logic             push_overflow, notify, pop_valid, pop_ipi;
   logic [PAY_W-1:0] pop_event;

   gen_event_queue #(.DEPTH(DEPTH), .PAY_W(PAY_W), .IPI_CODE(IPI), .NOTIFY_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_event(push_event),
      .push_overflow(push_overflow), .notify(notify), .pop_req(pop_req),
      .pop_valid(pop_valid), .pop_event(pop_event), .pop_ipi(pop_ipi)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int               q[$];
   logic             exp_valid = 1'b0, exp_ipi = 1'b0, exp_notify = 1'b0, exp_ovf = 1'b0;
   logic [PAY_W-1:0] exp_event = '0;
   bit               seen_edge = 1'b0;
   string            phase_tag = "R6";
   int               checks = 0;
   int               errors = 0;
   int               consumed = 0;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Behavioural reference: an unbounded queue limited to DEPTH entries
   always @(posedge clk) begin
      seen_edge = 1'b1;
      if (!rst_n) begin
         q.delete();
         exp_valid = 0; exp_event = '0; exp_ipi = 0; exp_notify = 0; exp_ovf = 0;
      end else begin
         exp_ovf = 0; exp_notify = 0;
         if (push_valid) begin
            if (q.size() == DEPTH) exp_ovf = 1;
            else begin q.push_back(int'(push_event)); exp_notify = 1; end
         end
         exp_valid = 0; exp_event = '0; exp_ipi = 0;
         if (pop_req && q.size() > 0) begin
            int v;
            v = q.pop_front();
            exp_valid = 1; exp_event = PAY_W'(v); exp_ipi = (v == IPI);
         end
      end
   end

   always @(negedge clk) begin
      if (seen_edge) begin
         chk(phase_tag, "pop_valid", 32'(pop_valid), 32'(exp_valid));
         chk(phase_tag, "pop_event", 32'(pop_event), 32'(exp_event));
         chk("R10", "pop_ipi", 32'(pop_ipi), 32'(exp_ipi));
         chk("R9", "notify", 32'(notify), 32'(exp_notify));
         chk("R7", "push_overflow", 32'(push_overflow), 32'(exp_ovf));
      end
   end

   task automatic step(input logic pv, input logic [PAY_W-1:0] ev, input logic pp);
      push_valid = pv; push_event = ev; pop_req = pp;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      phase_tag = "R2";
      repeat (3) step(0, '0, 1);
      step(1, 31'd5, 0);
      step(0, '0, 1);
      step(0, '0, 0);
      consumed += 1;

      phase_tag = "R8";
      step(1, 31'h77, 1);
      step(0, '0, 0);
      consumed += 1;

      // Align the consumer to slot 0, then check empty at the boundary
      phase_tag = "R3";
      for (int i = 0; i < DEPTH - (consumed % DEPTH); i++) step(1, PAY_W'(500 + i), 0);
      for (int i = 0; i < DEPTH - (consumed % DEPTH); i++) step(0, '0, 1);
      phase_tag = "R4";
      step(0, '0, 1);
      step(0, '0, 0);

      for (int lap = 0; lap < 3; lap++) begin
         phase_tag = "R3";
         for (int i = 0; i < DEPTH; i++) step(1, PAY_W'(lap * 100 + i + 1), 0);
         phase_tag = "R7";
         step(1, 31'h3ff, 0);
         step(1, 31'h3fe, 0);
         phase_tag = (lap == 0) ? "R3" : "R5";
         for (int i = 0; i < DEPTH; i++) step(0, '0, 1);
         phase_tag = "R4";
         step(0, '0, 1);
         step(0, '0, 0);
      end

      phase_tag = "R10";
      step(1, PAY_W'(IPI), 0);
      step(1, PAY_W'(IPI + 1), 0);
      step(1, PAY_W'(IPI - 1), 0);
      repeat (3) step(0, '0, 1);
      step(0, '0, 0);

      phase_tag = "R1";
      step(1, 31'h7fff_ffff, 0);
      step(1, 31'h0, 0);
      repeat (3) step(0, '0, 1);

      phase_tag = "R11";
      step(1, 31'd9, 0);
      step(0, '0, 1);
      step(0, '0, 0);
      step(0, '0, 0);

      phase_tag = "R3";
      begin
         logic [15:0] lf;
         lf = 16'hACE1;
         for (int n = 0; n < 800; n++) begin
            logic [PAY_W-1:0] ev;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            ev = (lf[7:4] == 4'h0) ? PAY_W'(IPI) : PAY_W'({lf, lf[3:0]});
            step(lf[0] | lf[9], ev, lf[1] & (n > 200 || lf[2]));
         end
      end
      step(0, '0, 0);
      step(0, '0, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 100000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule